// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block watches a set of level-sensitive interrupt inputs and turns each rising edge into a single 64-bit trigger store. The store goes to a notification address that software programs. The trigger word is the upper half of a programmable offset register, combined by OR with the index of the source that fired. A flag bit is added when the source marked its pending/queued state as already checked at the time it rose. The stores wait in a small queue and leave the block over a valid/ready handshake. A downstream bus agent then turns each one into an 8-byte big-endian write.

The block also holds the configuration that travels with this notification path, behind a simple register port with single-cycle access:

- a general control register with a store-style end-of-interrupt enable;
- an interrupt-control register, with a method bit that shuts off the edge path and a self-clearing source-reset request;
- a page-region base register, with map and unmap events and a large-page select;
- the notification address and the offset;
- a read-only mirror of the input levels.

If several inputs rise together, they are remembered as pending and drained one per cycle, lowest index first.

Top module: `irq_notify_gen`

## Requirements
- R1: The level register at offset 0x78 holds input n in bit (63 − n), with 1 meaning asserted, one cycle after the input is sampled. Writes to 0x78 leave it unchanged.
- R2: A rising edge on input n while the path is enabled produces one store. Its address is the notification register (0x68) with bit 0 cleared. Its data is (offset register 0x70 >> 32) OR n OR, when irq_pq_in[n] was high at the edge, bit 31.
- R3: When bit 0 of the notification register is 0 at the time a pending source is served, that trigger is discarded and no store appears.
- R4: Sources that are pending together are served one per cycle in ascending index order. The first store appears two cycles after the input edge is sampled.
- R5: While bit 63 of the interrupt-control register (0x58) is 1, input edges create no trigger and the level register is frozen. err_method pulses in the cycle after any input changes.
- R6: A write to 0x58 with bit 62 set pulses src_reset for exactly one cycle.
- R7: For the region base register (0x60), a write that changes bit 0 from 0 to 1 pulses esb_map, and one that changes it from 1 to 0 pulses esb_unmap. esb_64k follows bit 62. esb_base is the register with bits 0 and 62 cleared.
- R8: eoi_store_en follows bit 51 of the control register at 0x20.
- R9: A read of any offset other than 0x20, 0x58, 0x60, 0x68, 0x70 or 0x78 returns all ones and pulses err_rd in the following cycle.
- R10: Stores are held in a 4-entry queue, and st_addr/st_data stay stable while st_valid is high and st_ready is low. A trigger that finds the queue full, with no pop in the same cycle, is dropped, and err_ovf pulses.
- R11: After reset all registers read zero, st_valid is low and every pulse output is low.
- R12: The registers at 0x20, 0x58, 0x60, 0x68 and 0x70 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt input levels |
| irq_pq_in | input | NUM_SRC | Per-source "state already checked" qualifier, sampled on the rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, same cycle |
| err_rd | output | 1 | Pulse after a read of an unimplemented offset |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data (trigger word) |
| err_ovf | output | 1 | Pulse when a trigger is lost to a full queue |
| err_method | output | 1 | Pulse when inputs change while the path is disabled |
| src_reset | output | 1 | One-cycle reset request to downstream source state |
| esb_map | output | 1 | Pulse when the region becomes valid |
| esb_unmap | output | 1 | Pulse when the region becomes invalid |
| esb_64k | output | 1 | Large-page select |
| esb_base | output | 64 | Region base address |
| eoi_store_en | output | 1 | Store-style end-of-interrupt enable |

## Verification
The trigger path is driven in four ways:

- **Isolated single edges**, with and without the checked qualifier, separate the offset, index and flag fields of the data word.
- **Bursts of simultaneous edges with the sink stalled** show the drain order, then fill the queue and push it past capacity, which separates a correct drop from a reordering or a stall.
- **Edges while the notification is invalid, and edges while the method bit is set**, separate "served but discarded" from "never accepted".
- **A long pseudo-random stretch** toggles inputs and qualifiers, with the handshake ready changing on every cycle. It exercises same-cycle push-and-pop at a full queue and re-arming of a source that is being served.

A behavioural queue model predicts every output on every clock.

// File: rtl/irq_notify_pkg.sv
package irq_notify_pkg;

    localparam int REG_W = 64;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_INTCTL = 8'h58;
    localparam logic [7:0] OFS_REGION = 8'h60;
    localparam logic [7:0] OFS_NOTIF  = 8'h68;
    localparam logic [7:0] OFS_OFFSET = 8'h70;
    localparam logic [7:0] OFS_LEVEL  = 8'h78;

    // Bit positions (LSB = bit 0)
    localparam int METHOD_BIT    = 63;
    localparam int SRCRST_BIT    = 62;
    localparam int REGION_VLD    = 0;
    localparam int REGION_BIG    = 62;
    localparam int NOTIF_VLD     = 0;
    localparam int EOI_STORE_BIT = 51;
    localparam int OFFSET_SHIFT  = 32;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } store_req_t;

endpackage

// File: rtl/irq_notify_regs.sv
module irq_notify_regs
    import irq_notify_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  level,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              err_rd,
    output logic              method,
    output logic              src_reset,
    output logic              esb_map,
    output logic              esb_unmap,
    output logic              esb_64k,
    output logic [REG_W-1:0]  esb_base,
    output logic              eoi_store_en,
    output logic              notif_vld,
    output logic [REG_W-1:0]  notif_addr,
    output logic [31:0]       offset_hi
);

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] intctl;
        logic [REG_W-1:0] region;
        logic [REG_W-1:0] notif;
        logic [REG_W-1:0] offset;
        logic             srcrst;
        logic             map;
        logic             unmap;
        logic             err_rd;
    } regs_t;

    regs_t r_q, r_d;

    logic hit_ctrl, hit_intctl, hit_region, hit_notif, hit_offset, hit_level;

    always_comb begin
        hit_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
        hit_intctl = (reg_addr == ADDR_W'(OFS_INTCTL));
        hit_region = (reg_addr == ADDR_W'(OFS_REGION));
        hit_notif  = (reg_addr == ADDR_W'(OFS_NOTIF));
        hit_offset = (reg_addr == ADDR_W'(OFS_OFFSET));
        hit_level  = (reg_addr == ADDR_W'(OFS_LEVEL));
    end

    // Next state
    always_comb begin
        r_d        = r_q;
        r_d.srcrst = 1'b0;
        r_d.map    = 1'b0;
        r_d.unmap  = 1'b0;
        r_d.err_rd = 1'b0;
        if (reg_wr) begin
            if (hit_ctrl) begin
                r_d.ctrl = reg_wdata;
            end
            if (hit_intctl) begin
                r_d.intctl = reg_wdata;
                r_d.srcrst = reg_wdata[SRCRST_BIT];
            end
            if (hit_region) begin
                r_d.region = reg_wdata;
                r_d.map    = reg_wdata[REGION_VLD] & ~r_q.region[REGION_VLD];
                r_d.unmap  = ~reg_wdata[REGION_VLD] & r_q.region[REGION_VLD];
            end
            if (hit_notif) begin
                r_d.notif = reg_wdata;
            end
            if (hit_offset) begin
                r_d.offset = reg_wdata;
            end
        end
        if (reg_rd && !(hit_ctrl || hit_intctl || hit_region ||
                        hit_notif || hit_offset || hit_level)) begin
            r_d.err_rd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux (combinational)
    always_comb begin
        if (hit_ctrl)        reg_rdata = r_q.ctrl;
        else if (hit_intctl) reg_rdata = r_q.intctl;
        else if (hit_region) reg_rdata = r_q.region;
        else if (hit_notif)  reg_rdata = r_q.notif;
        else if (hit_offset) reg_rdata = r_q.offset;
        else if (hit_level)  reg_rdata = level;
        else                 reg_rdata = '1;
    end

    always_comb begin
        err_rd       = r_q.err_rd;
        method       = r_q.intctl[METHOD_BIT];
        src_reset    = r_q.srcrst;
        esb_map      = r_q.map;
        esb_unmap    = r_q.unmap;
        esb_64k      = r_q.region[REGION_BIG];
        esb_base     = r_q.region;
        esb_base[REGION_VLD] = 1'b0;
        esb_base[REGION_BIG] = 1'b0;
        eoi_store_en = r_q.ctrl[EOI_STORE_BIT];
        notif_vld    = r_q.notif[NOTIF_VLD];
        notif_addr   = r_q.notif;
        notif_addr[NOTIF_VLD] = 1'b0;
        offset_hi    = r_q.offset[REG_W-1:OFFSET_SHIFT];
    end

endmodule

// File: rtl/irq_notify_pending.sv
module irq_notify_pending
    import irq_notify_pkg::*;
#(
    parameter int NUM_SRC = 20,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] irq_pq_in,
    input  logic               method,
    output logic [REG_W-1:0]   level,
    output logic               grant_vld,
    output logic [SRC_W-1:0]   grant_idx,
    output logic               grant_pq,
    output logic               err_method
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] pq;
        logic [REG_W-1:0]   lvl;
        logic               err;
    } pend_t;

    pend_t s_q, s_d;

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] grant_oh;

    // Lowest-index pending source
    always_comb begin
        grant_oh  = s_q.pend & (~s_q.pend + 1'b1);
        grant_vld = |s_q.pend;
        grant_pq  = |(grant_oh & s_q.pq);
        grant_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_oh[i]) grant_idx = SRC_W'(i);
        end
    end

    always_comb begin
        rise   = method ? '0 : (irq_in & ~s_q.prev);
        s_d    = s_q;
        s_d.prev = irq_in;
        s_d.pend = (s_q.pend & ~grant_oh) | rise;
        s_d.pq   = (s_q.pq & ~grant_oh & ~rise) | (rise & irq_pq_in);
        s_d.err  = method & (irq_in != s_q.prev);
        if (!method) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                s_d.lvl[REG_W-1-i] = irq_in[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level      = s_q.lvl;
    assign err_method = s_q.err;

endmodule

// File: rtl/irq_notify_fifo.sv
module irq_notify_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 128,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_vld,
    output logic [W-1:0] out_data,
    output logic         ovf
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t f_q, f_d;

    logic do_pop, do_push;

    always_comb begin
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && ((f_q.cnt < CNT_W'(DEPTH)) || do_pop);
        f_d     = f_q;
        f_d.ovf = push && !do_push;
        if (do_push) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr = (f_q.wr == PTR_W'(DEPTH - 1)) ? '0 : f_q.wr + 1'b1;
        end
        if (do_pop) begin
            f_d.rd = (f_q.rd == PTR_W'(DEPTH - 1)) ? '0 : f_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign out_vld  = (f_q.cnt != '0);
    assign out_data = f_q.mem[f_q.rd];
    assign ovf      = f_q.ovf;

endmodule

// File: rtl/irq_notify_gen.sv
module irq_notify_gen
    import irq_notify_pkg::*;
#(
    parameter int NUM_SRC    = 20,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 8,
    parameter int TRIG_BIT   = 31,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] irq_pq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               err_rd,
    output logic               st_valid,
    input  logic               st_ready,
    output logic [63:0]        st_addr,
    output logic [63:0]        st_data,
    output logic               err_ovf,
    output logic               err_method,
    output logic               src_reset,
    output logic               esb_map,
    output logic               esb_unmap,
    output logic               esb_64k,
    output logic [63:0]        esb_base,
    output logic               eoi_store_en
);

    logic [REG_W-1:0] level;
    logic             method;
    logic             notif_vld;
    logic [REG_W-1:0] notif_addr;
    logic [31:0]      offset_hi;
    logic             grant_vld;
    logic [SRC_W-1:0] grant_idx;
    logic             grant_pq;
    store_req_t       push_req;
    store_req_t       head_req;

    irq_notify_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .level        (level),
        .reg_rdata    (reg_rdata),
        .err_rd       (err_rd),
        .method       (method),
        .src_reset    (src_reset),
        .esb_map      (esb_map),
        .esb_unmap    (esb_unmap),
        .esb_64k      (esb_64k),
        .esb_base     (esb_base),
        .eoi_store_en (eoi_store_en),
        .notif_vld    (notif_vld),
        .notif_addr   (notif_addr),
        .offset_hi    (offset_hi)
    );

    irq_notify_pending #(.NUM_SRC(NUM_SRC)) pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .irq_pq_in  (irq_pq_in),
        .method     (method),
        .level      (level),
        .grant_vld  (grant_vld),
        .grant_idx  (grant_idx),
        .grant_pq   (grant_pq),
        .err_method (err_method)
    );

    // Trigger word: offset | source | optional checked flag
    always_comb begin
        push_req.addr = notif_addr;
        push_req.data = {32'b0, offset_hi}
                      | {{(REG_W - SRC_W){1'b0}}, grant_idx}
                      | (grant_pq ? (64'd1 << TRIG_BIT) : 64'd0);
    end

    irq_notify_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(store_req_t))) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant_vld && notif_vld),
        .push_data (push_req),
        .pop       (st_ready),
        .out_vld   (st_valid),
        .out_data  (head_req),
        .ovf       (err_ovf)
    );

    assign st_addr = head_req.addr;
    assign st_data = head_req.data;

endmodule

// File: rtl/irq_notify_chk.sv
module irq_notify_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [63:0]       reg_wdata,
    input logic [63:0]       reg_rdata,
    input logic              err_rd,
    input logic              st_valid,
    input logic              st_ready,
    input logic [63:0]       st_addr,
    input logic [63:0]       st_data,
    input logic              src_reset,
    input logic              esb_map,
    input logic              esb_unmap
);

    logic known;
    always_comb begin
        known = (reg_addr == ADDR_W'(8'h20)) || (reg_addr == ADDR_W'(8'h58)) ||
                (reg_addr == ADDR_W'(8'h60)) || (reg_addr == ADDR_W'(8'h68)) ||
                (reg_addr == ADDR_W'(8'h70)) || (reg_addr == ADDR_W'(8'h78));
    end

    a_r9_unknown_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !known) |-> (reg_rdata == 64'hFFFF_FFFF_FFFF_FFFF));

    a_r9_unknown_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !known) |=> err_rd);

    a_r6_reset_request: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h58) && reg_wdata[62]) |=> src_reset);

    a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));

    a_r2_addr_no_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !st_addr[0]);

    a_r7_map_unmap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({esb_map, esb_unmap}));

endmodule

bind irq_notify_gen irq_notify_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .err_rd    (err_rd),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .src_reset (src_reset),
    .esb_map   (esb_map),
    .esb_unmap (esb_unmap)
);

// File: tb/irq_notify_gen_tb_top.sv
module irq_notify_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 20;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic [NSRC-1:0] irq_pq_in = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            err_rd, st_valid, err_ovf, err_method, src_reset;
    logic            esb_map, esb_unmap, esb_64k, eoi_store_en;
    logic            st_ready = 1'b0;
    logic [63:0]     st_addr, st_data, esb_base;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_notify_gen dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_pq_in(irq_pq_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_rd(err_rd),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .err_ovf(err_ovf), .err_method(err_method),
        .src_reset(src_reset), .esb_map(esb_map), .esb_unmap(esb_unmap),
        .esb_64k(esb_64k), .esb_base(esb_base), .eoi_store_en(eoi_store_en)
    );

    // ---------------- reference model ----------------
    logic [127:0]    mq[$];
    logic [NSRC-1:0] m_prev, m_pend, m_pq;
    logic [63:0]     m_level, m_ctrl, m_intctl, m_region, m_notif, m_offset;
    logic            e_ovf, e_meth, e_srst, e_map, e_unmap, e_rd;
    int              gidx;
    logic            gpq;
    logic [63:0]     gdata;

    function automatic logic is_known(input logic [7:0] a);
        return a == 8'h20 || a == 8'h58 || a == 8'h60 || a == 8'h68 ||
               a == 8'h70 || a == 8'h78;
    endfunction

    function automatic logic [63:0] m_read(input logic [7:0] a);
        case (a)
            8'h20:   return m_ctrl;
            8'h58:   return m_intctl;
            8'h60:   return m_region;
            8'h68:   return m_notif;
            8'h70:   return m_offset;
            8'h78:   return m_level;
            default: return '1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_prev = '0; m_pend = '0; m_pq = '0; m_level = '0;
            m_ctrl = '0; m_intctl = '0; m_region = '0; m_notif = '0; m_offset = '0;
            e_ovf = 0; e_meth = 0; e_srst = 0; e_map = 0; e_unmap = 0; e_rd = 0;
        end else begin
            if (mq.size() > 0 && st_ready) void'(mq.pop_front());
            gidx = -1;
            for (int i = 0; i < NSRC; i++) begin
                if (m_pend[i]) begin gidx = i; break; end
            end
            e_ovf = 0;
            if (gidx >= 0) begin
                gpq = m_pq[gidx];
                m_pend[gidx] = 1'b0;
                m_pq[gidx] = 1'b0;
                if (m_notif[0]) begin
                    gdata = {32'b0, m_offset[63:32]} | 64'(gidx) | (gpq ? 64'h8000_0000 : 64'h0);
                    if (mq.size() < DEPTH) mq.push_back({m_notif & ~64'd1, gdata});
                    else e_ovf = 1;
                end
            end
            e_meth = m_intctl[63] && (irq_in != m_prev);
            if (!m_intctl[63]) begin
                for (int i = 0; i < NSRC; i++) begin
                    if (irq_in[i] && !m_prev[i]) begin
                        m_pend[i] = 1'b1;
                        m_pq[i] = irq_pq_in[i];
                    end
                    m_level[63-i] = irq_in[i];
                end
            end
            m_prev = irq_in;
            e_srst = 0; e_map = 0; e_unmap = 0;
            if (reg_wr) begin
                case (reg_addr)
                    8'h20: m_ctrl = reg_wdata;
                    8'h58: begin m_intctl = reg_wdata; e_srst = reg_wdata[62]; end
                    8'h60: begin
                        e_map   = reg_wdata[0] && !m_region[0];
                        e_unmap = !reg_wdata[0] && m_region[0];
                        m_region = reg_wdata;
                    end
                    8'h68: m_notif = reg_wdata;
                    8'h70: m_offset = reg_wdata;
                    default: ;
                endcase
            end
            e_rd = reg_rd && !is_known(reg_addr);
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(st_valid == (mq.size() > 0), "R10", "st_valid", 64'(st_valid), 64'(mq.size() > 0));
            if (mq.size() > 0) begin
                check(st_addr == mq[0][127:64], "R2", "st_addr", st_addr, mq[0][127:64]);
                check(st_data == mq[0][63:0], "R2", "st_data", st_data, mq[0][63:0]);
            end
            check(err_ovf == e_ovf, "R10", "err_ovf", 64'(err_ovf), 64'(e_ovf));
            check(err_method == e_meth, "R5", "err_method", 64'(err_method), 64'(e_meth));
            check(src_reset == e_srst, "R6", "src_reset", 64'(src_reset), 64'(e_srst));
            check(esb_map == e_map, "R7", "esb_map", 64'(esb_map), 64'(e_map));
            check(esb_unmap == e_unmap, "R7", "esb_unmap", 64'(esb_unmap), 64'(e_unmap));
            check(esb_64k == m_region[62], "R7", "esb_64k", 64'(esb_64k), 64'(m_region[62]));
            check(esb_base == (m_region & ~64'h4000_0000_0000_0001), "R7", "esb_base",
                  esb_base, m_region & ~64'h4000_0000_0000_0001);
            check(eoi_store_en == m_ctrl[51], "R8", "eoi_store_en", 64'(eoi_store_en), 64'(m_ctrl[51]));
            check(err_rd == e_rd, "R9", "err_rd", 64'(err_rd), 64'(e_rd));
            if (reg_rd) begin
                if (reg_addr == 8'h78)
                    check(reg_rdata == m_read(reg_addr), "R1", "level read", reg_rdata, m_read(reg_addr));
                else if (!is_known(reg_addr))
                    check(reg_rdata == m_read(reg_addr), "R9", "unmapped read", reg_rdata, m_read(reg_addr));
                else
                    check(reg_rdata == m_read(reg_addr), "R12", "readback", reg_rdata, m_read(reg_addr));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_rd = 1'b1; reg_addr = a;
        tick(1);
        reg_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    logic [31:0] lfsr;

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11: reset state
        @(negedge clk);
        check(st_valid == 1'b0, "R11", "st_valid after reset", 64'(st_valid), 64'd0);
        check(reg_rdata == 64'hFFFF_FFFF_FFFF_FFFF, "R11", "idle rdata", reg_rdata, '1);
        tick(0);
        rd(8'h78); rd(8'h68); rd(8'h58);

        // Configuration and readback (R8, R12)
        wr(8'h68, 64'h0000_1000_0000_2001);
        wr(8'h70, 64'h0000_0100_0000_0000);
        wr(8'h20, 64'h0008_0000_0000_0000);
        rd(8'h68); rd(8'h70); rd(8'h20);

        // Single edges, with and without the checked flag (R2, R1)
        st_ready = 1'b1;
        irq_in[3] = 1'b1;
        tick(3);
        rd(8'h78);
        irq_in[3] = 1'b0;
        irq_pq_in[19] = 1'b1;
        irq_in[19] = 1'b1;
        tick(3);
        rd(8'h78);
        irq_in = '0; irq_pq_in = '0;
        tick(2);

        // Simultaneous edges, sink stalled (R4)
        st_ready = 1'b0;
        irq_in = 20'h000A4;   // sources 2, 5, 7
        tick(2);
        @(negedge clk);
        check(st_data[4:0] == 5'd2, "R4", "first served source", 64'(st_data[4:0]), 64'd2);
        tick(0);
        tick(3);
        irq_in = '0;
        tick(1);
        // Overflow: sources 8..12 arrive with one slot left (R10)
        irq_in = 20'h01F00;
        tick(8);
        irq_in = '0;
        st_ready = 1'b1;
        tick(8);

        // Notification invalid: trigger discarded (R3)
        wr(8'h68, 64'h0000_1000_0000_2000);
        irq_in[1] = 1'b1;
        tick(4);
        @(negedge clk);
        check(st_valid == 1'b0, "R3", "no store when invalid", 64'(st_valid), 64'd0);
        tick(0);
        irq_in[1] = 1'b0;
        wr(8'h68, 64'h0000_1000_0000_2001);
        tick(1);

        // Method bit: edges ignored, level frozen (R5)
        wr(8'h58, 64'h8000_0000_0000_0000);
        irq_in = 20'h00011;
        tick(2);
        irq_in = 20'h00010;
        tick(3);
        rd(8'h78);
        wr(8'h58, 64'h0);
        tick(3);
        rd(8'h78);
        irq_in = '0;
        tick(3);

        // Source reset request (R6)
        wr(8'h58, 64'h4000_0000_0000_0000);
        tick(1);
        rd(8'h58);

        // Region register events (R7)
        wr(8'h60, 64'h4000_0000_ABC0_0001);
        wr(8'h60, 64'h0000_0000_ABC0_0001);
        wr(8'h60, 64'h0000_0000_ABC0_0000);
        rd(8'h60);
        tick(1);

        // Unimplemented reads and read-only level (R9, R1)
        rd(8'h00); rd(8'h28); rd(8'h80);
        tick(1);
        wr(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h78);

        // Pseudo-random traffic with a toggling sink (R2, R4, R10)
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            irq_in    = lfsr[19:0] & lfsr[31:12];
            irq_pq_in = lfsr[24:5];
            st_ready  = lfsr[7] | lfsr[13];
            if (k == 150) wr(8'h70, 64'h0000_0200_0000_0000);
            else tick(1);
        end
        irq_in = '0;
        st_ready = 1'b1;
        tick(30);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule